// File: doc/BRIEF.md
# Variable-Precision Bit-Serial Dot-Product Unit

This unit forms the sum of products of a small vector of signed activations and a matching vector of signed weights, and uses no multiplier. It reads the weights one bit column at a time, from the most significant bit down. Each cycle the running total is doubled, and the activations whose weight bit in that column is set are added to it. On the sign column they are subtracted instead. Every lane is handled in the same cycle.

The caller chooses, per operation, how many of the top weight bits take part, from 1 to 16. Fewer bits means fewer cycles. The unit also stops as soon as every remaining weight bit in every lane is zero. When all truncated weights are zero it answers at once. The result is scaled back to full weight weight, so a truncated run matches an exact dot product taken with the low weight bits cleared.

A single `start` pulse loads the operands and the precision. `busy` stays high while the bit columns are walked, and `done` marks the one cycle in which a new `result` appears.

Top module: `vpdp_dot`

## Requirements
- R1: `result` is the exact signed dot product sum(a_i * w'_i), where each activation a_i and weight w_i is a 16-bit two's complement lane value and w'_i is w_i with its low (16 - P) bits cleared. P is the effective precision. Lane i sits at bits [16i+15:16i] of `act_vec` and `wgt_vec`, and `result` is 34-bit two's complement.
- R2: Bits are consumed one per cycle, most significant first. If the lowest set bit of the OR of all truncated weights is at position b, `done` is high in the cycle after the (16 - b)-th rising edge that follows the accepting edge. With full use of P bits this is P cycles, for example 8 cycles for P = 8.
- R3: The `prec` input is read as an unsigned count. A value of 0 acts as 1, and any value above 16 acts as 16.
- R4: If every truncated weight is zero, `done` is high in the cycle right after the accepting edge and `result` is 0.
- R5: The operation finishes early once all lower truncated weight bits are zero in every lane. A bit column that has no set bit in any lane only doubles the partial sum and adds nothing.
- R6: `done` is a one-cycle pulse and `busy` is low while it is high. A `start` seen while `busy` is low is accepted, including in the cycle `done` is high. After acceptance, either `busy` or `done` is high in the next cycle.
- R7: A `start` pulse while `busy` is high is ignored and does not change the result of the running operation.
- R8: Operands and precision are captured at the accepting edge. Changing `act_vec`, `wgt_vec` or `prec` during a run affects neither the result nor the run length.
- R9: `result` holds its value in every cycle in which `done` is low.
- R10: After reset, `busy` and `done` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| act_vec | input | LANES*AW | Packed signed activations, lane 0 in the low bits |
| wgt_vec | input | LANES*WW | Packed signed weights, lane 0 in the low bits |
| prec | input | PW | Requested number of weight bits |
| busy | output | 1 | Bit columns are being processed |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | RW | Signed dot product of the last operation |

## Verification
The bench sweeps every precision value from 0 to 20 against patterns that include all-minimum operands, all-maximum operands, all-zero weights and weights whose only set bits lie below the precision cut. It predicts both the product and the exact completion cycle.

A design that misses the sign-column subtraction gives wrong results on negative weights. One that forgets to realign a truncated or early-stopped sum returns a value too small by a power of two. One that does not clamp the precision runs the wrong number of cycles.

Further stimulus changes the inputs and pulses `start` during a run, and starts a new operation in the very cycle `done` is high. These catch a design that resamples its operands, that accepts a start while busy, or that drops a back-to-back request.

// File: rtl/vpdp_pkg.sv
package vpdp_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vpdp_state_t;

  // Effective precision: below 1 becomes 1, above the weight width becomes it.
  function automatic int clamp_prec(input int p, input int maxp);
    if (p < 1) return 1;
    if (p > maxp) return maxp;
    return p;
  endfunction

  // Left shift that restores full weight scale after consuming 'used' bits.
  function automatic int realign_shift(input int width, input int used);
    return width - used;
  endfunction

endpackage

// File: rtl/vpdp_col_sum.sv
module vpdp_col_sum #(
  parameter int LANES = 4,
  parameter int AW    = 16,
  parameter int RW    = 34
) (
  input  logic [LANES*AW-1:0] act,
  input  logic [LANES-1:0]    sel,
  output logic signed [RW-1:0] sum
);

  logic signed [RW-1:0] lane_term [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_term[g] = sel[g] ? RW'($signed(act[g*AW +: AW])) : '0;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++) begin
      sum = sum + lane_term[i];
    end
  end

endmodule

// File: rtl/vpdp_zero_scan.sv
module vpdp_zero_scan #(
  parameter int LANES = 4,
  parameter int WW    = 16
) (
  input  logic [LANES*WW-1:0] wvec,
  output logic                col_any,
  output logic                rest_zero
);

  logic [LANES-1:0] top_bit;
  logic [LANES-1:0] low_nz;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign top_bit[g] = wvec[g*WW + WW - 1];
    if (WW > 1) begin : g_low
      assign low_nz[g] = |wvec[g*WW +: WW-1];
    end else begin : g_nolow
      assign low_nz[g] = 1'b0;
    end
  end

  assign col_any   = |top_bit;
  assign rest_zero = ~|low_nz;

endmodule

// File: rtl/vpdp_ctrl.sv
module vpdp_ctrl
  import vpdp_pkg::*;
#(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          load_zero,
  input  logic          rest_zero,
  input  logic [PW-1:0] prec_eff,
  output logic          busy,
  output logic          accept,
  output logic          run_fin,
  output logic          first,
  output logic [PW-1:0] step
);

  vpdp_state_t   st_q;
  logic [PW-1:0] step_q;
  logic [PW-1:0] prec_q;
  logic          last_col;

  assign busy     = (st_q == ST_RUN);
  assign accept   = start && (st_q == ST_IDLE);
  assign last_col = rest_zero || (step_q == prec_q - PW'(1));
  assign run_fin  = busy && last_col;
  assign first    = (step_q == '0);
  assign step     = step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      prec_q <= PW'(1);
    end else if (accept) begin
      prec_q <= prec_eff;
      step_q <= '0;
      st_q   <= load_zero ? ST_IDLE : ST_RUN;
    end else if (busy) begin
      step_q <= step_q + PW'(1);
      if (last_col) st_q <= ST_IDLE;
    end
  end

endmodule

// File: rtl/vpdp_dot.sv
module vpdp_dot
  import vpdp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 16,
  parameter int WW    = 16,
  parameter int PW    = $clog2(WW + 1),
  parameter int RW    = AW + WW + $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LANES*AW-1:0] act_vec,
  input  logic [LANES*WW-1:0] wgt_vec,
  input  logic [PW-1:0]       prec,
  output logic                busy,
  output logic                done,
  output logic [RW-1:0]       result
);

  localparam int WTOT = LANES * WW;
  localparam int ATOT = LANES * AW;

  // Load path: effective precision and truncated weights
  logic [PW-1:0]   prec_eff;
  logic [WW-1:0]   keep_mask;
  logic [WTOT-1:0] w_trunc;

  always_comb begin
    prec_eff = PW'(clamp_prec(int'(prec), WW));
    for (int b = 0; b < WW; b++) begin
      keep_mask[b] = (b >= WW - int'(prec_eff));
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_trunc
    assign w_trunc[g*WW +: WW] = wgt_vec[g*WW +: WW] & keep_mask;
  end

  logic ld_col_any, ld_rest_zero, load_zero;

  vpdp_zero_scan #(.LANES(LANES), .WW(WW)) u_load_scan (
    .wvec      (w_trunc),
    .col_any   (ld_col_any),
    .rest_zero (ld_rest_zero)
  );

  assign load_zero = !ld_col_any && ld_rest_zero;

  // Operand registers
  logic [WTOT-1:0]      w_q;
  logic [ATOT-1:0]      a_q;
  logic signed [RW-1:0] acc_q;
  logic [RW-1:0]        result_q;
  logic                 done_q;

  // Run path: current bit column
  logic col_any, rest_zero;

  vpdp_zero_scan #(.LANES(LANES), .WW(WW)) u_run_scan (
    .wvec      (w_q),
    .col_any   (col_any),
    .rest_zero (rest_zero)
  );

  logic [LANES-1:0] col_sel;
  for (genvar g = 0; g < LANES; g++) begin : g_sel
    assign col_sel[g] = w_q[g*WW + WW - 1];
  end

  logic signed [RW-1:0] col_sum;

  vpdp_col_sum #(.LANES(LANES), .AW(AW), .RW(RW)) u_col_sum (
    .act (a_q),
    .sel (col_sel),
    .sum (col_sum)
  );

  // Control
  logic          accept, run_fin, first;
  logic [PW-1:0] step_q;

  vpdp_ctrl #(.PW(PW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_zero (load_zero),
    .rest_zero (rest_zero),
    .prec_eff  (prec_eff),
    .busy      (busy),
    .accept    (accept),
    .run_fin   (run_fin),
    .first     (first),
    .step      (step_q)
  );

  // Named events for the checker
  logic add_en, skip_ev;
  assign add_en  = busy && col_any;
  assign skip_ev = busy && !col_any;

  logic signed [RW-1:0] col_term, acc_nx, fin_val;
  int                   sh;

  always_comb begin
    col_term = first ? -col_sum : col_sum;
    acc_nx   = (acc_q <<< 1) + (add_en ? col_term : '0);
    sh       = realign_shift(WW, int'(step_q) + 1);
    fin_val  = acc_nx <<< sh;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_wshift
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q[g*WW +: WW] <= '0;
      end else if (accept) begin
        w_q[g*WW +: WW] <= w_trunc[g*WW +: WW];
      end else if (busy) begin
        w_q[g*WW +: WW] <= {w_q[g*WW +: WW-1], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q      <= '0;
      acc_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (accept && load_zero) || run_fin;
      if (accept) begin
        a_q   <= act_vec;
        acc_q <= '0;
      end else if (busy) begin
        acc_q <= acc_nx;
      end
      if (accept && load_zero) begin
        result_q <= '0;
      end else if (run_fin) begin
        result_q <= fin_val;
      end
    end
  end

  assign done   = done_q;
  assign result = result_q;

endmodule

// File: rtl/vpdp_dot_chk.sv
module vpdp_dot_chk #(
  parameter int WW = 16,
  parameter int PW = 5,
  parameter int RW = 34
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [RW-1:0]        result,
  input logic signed [RW-1:0] acc_q,
  input logic                 skip_ev,
  input logic                 load_zero,
  input logic [PW-1:0]        step_q
);

  logic [PW:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < (PW+1)'(WW)));

  assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(step_q) < WW));

  assert_zero_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && load_zero) |=> (done && result == '0));

  assert_skip_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    skip_ev |=> (acc_q == ($past(acc_q) <<< 1)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy || done));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

bind vpdp_dot vpdp_dot_chk #(.WW(WW), .PW(PW), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .acc_q     (acc_q),
  .skip_ev   (skip_ev),
  .load_zero (load_zero),
  .step_q    (step_q)
);

// File: tb/vpdp_dot_test.sv
`timescale 1ns/1ps
module vpdp_dot_test;

  localparam int LANES = 4;
  localparam int AW = 16;
  localparam int WW = 16;
  localparam int PW = 5;
  localparam int RW = 34;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rst_n, start, busy, done;
  logic [LANES*AW-1:0] act_vec;
  logic [LANES*WW-1:0] wgt_vec;
  logic [PW-1:0]       prec;
  logic [RW-1:0]       result;

  vpdp_dot uut (
    .clk(clk), .rst_n(rst_n), .start(start), .act_vec(act_vec),
    .wgt_vec(wgt_vec), .prec(prec), .busy(busy), .done(done), .result(result)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic signed [15:0] ta [LANES];
  logic signed [15:0] tw [LANES];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int peff(input int p);
    return (p < 1) ? 1 : ((p > 16) ? 16 : p);
  endfunction

  function automatic longint ref_dot(input int p);
    int sh;
    longint s;
    sh = 16 - peff(p);
    s = 0;
    for (int i = 0; i < LANES; i++)
      s += longint'(ta[i]) * ((longint'(tw[i]) >>> sh) <<< sh);
    return s;
  endfunction

  // Falling edges from accepting edge until done is seen
  function automatic int ref_lat(input int p);
    int sh;
    longint orv;
    sh = 16 - peff(p);
    orv = 0;
    for (int i = 0; i < LANES; i++)
      orv |= ((longint'(tw[i]) >>> sh) <<< sh) & 64'hFFFF;
    if (orv == 0) return 1;
    for (int b = 0; b < 16; b++)
      if (orv[b]) return (16 - b) + 1;
    return 1;
  endfunction

  task automatic drive_ops(input int p);
    for (int i = 0; i < LANES; i++) begin
      act_vec[i*AW +: AW] = ta[i];
      wgt_vec[i*WW +: WW] = tw[i];
    end
    prec = PW'(p);
  endtask

  // Starts and ends just after a falling edge; returns in the done cycle
  task automatic run_op(input int p);
    longint expv;
    int     expl, n;
    string  rtag, ltag;
    expv = ref_dot(p);
    expl = ref_lat(p);
    rtag = (p < 1 || p > 16) ? "R3" : (expv == 0 ? "R1/R4" : "R1");
    ltag = (expl == 1) ? "R4" : ((expl - 1 < peff(p)) ? "R5" : ((p < 1 || p > 16) ? "R3" : "R2"));
    drive_ops(p);
    start = 1'b1;
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      start = 1'b0;
      if (n == 1 && !done) chk(busy == 1'b1, "R6 busy after accept", longint'(busy), 1);
    end while (!done && n < 40);
    chk(longint'($signed(result)) == expv, rtag, longint'($signed(result)), expv);
    chk(n == expl, ltag, n, expl);
  endtask

  task automatic set_pattern(input int k);
    for (int i = 0; i < LANES; i++) begin
      case (k)
        0: begin ta[i] = 16'sh8000; tw[i] = 16'sh8000; end
        1: begin ta[i] = 16'sh7FFF; tw[i] = 16'sh7FFF; end
        2: begin ta[i] = 16'($urandom); tw[i] = '0; end
        3: begin ta[i] = 16'($urandom); tw[i] = 16'sh0001; end
        4: begin ta[i] = 16'sh8000; tw[i] = 16'sh4000; end
        5: begin ta[i] = 16'(100 * (i + 1) - 250); tw[i] = (i % 2 == 0) ? -16'sh1 : 16'(1 << (4 * i)); end
        10: begin ta[i] = 16'($urandom); tw[i] = {8'($urandom), 8'h00}; end
        11: begin ta[i] = 16'($urandom); tw[i] = (i == 2) ? 16'($urandom) | 16'h0010 : '0; end
        default: begin ta[i] = 16'($urandom); tw[i] = 16'($urandom); end
      endcase
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint expv, held;
    int     expl, n;
    rst_n = 1'b0;
    start = 1'b0;
    act_vec = '0;
    wgt_vec = '0;
    prec = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0, "R10 busy", longint'(busy), 0);
    chk(done == 1'b0, "R10 done", longint'(done), 0);
    chk(result == '0, "R10 result", longint'($signed(result)), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep all precisions, including clamped ones; back-to-back starts (R6)
    for (int p = 0; p <= 20; p++) begin
      for (int k = 0; k < 14; k++) begin
        set_pattern(k);
        run_op(p);
      end
    end

    // R6: done is a single pulse and busy stays low after it
    @(negedge clk);
    chk(done == 1'b0, "R6 done pulse", longint'(done), 0);
    chk(busy == 1'b0, "R6 idle", longint'(busy), 0);

    // R7/R8: inputs changed and start pulsed during a full-length run
    for (int i = 0; i < LANES; i++) begin
      ta[i] = 16'(37 * i - 70);
      tw[i] = (i == 0) ? 16'sh8001 : 16'(1234 * (i + 1));
    end
    expv = ref_dot(16);
    expl = ref_lat(16);
    drive_ops(16);
    start = 1'b1;
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n <= 3) begin
        start = 1'b1;
        act_vec = ~act_vec;
        wgt_vec = {LANES*WW{1'b1}};
        prec = PW'(2);
      end else begin
        start = 1'b0;
      end
    end while (!done && n < 40);
    chk(longint'($signed(result)) == expv, "R7 start ignored while busy", longint'($signed(result)), expv);
    chk(n == expl, "R8 captured precision", n, expl);

    // R9: result holds while done is low and inputs move
    held = longint'($signed(result));
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      act_vec = 64'($urandom) << 8;
      wgt_vec = 64'($urandom);
      chk(longint'($signed(result)) == held, "R9 result held", longint'($signed(result)), held);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule